// File: doc/BRIEF.md
# Nibble-Multiplexed Sample Output Formatter

This block takes finished 12-bit conversion results and sends them off-chip over a 4-bit bus. When the sample-valid strobe is sampled high, the block captures the sample, its overrange flag and its two-bit colour code. The sample can optionally be inverted digitally at that point. The captured word then waits for a programmable latency. After that, a nibble sequencer puts out three data nibbles, most significant first, followed by one status nibble. The sequencer moves one nibble per master-clock cycle and then holds the status nibble until the next word arrives.

Latency is set in converter-clock periods. One converter-clock period is two master clocks in the normal modes and three master clocks when the slow-divide mode is selected. The converter-clock phase counter restarts on every sample strobe. A test selection replaces the data on the pins with four internal timing signals. The captured data keeps flowing underneath, so leaving test mode shows the data that is current at that moment.

Top module: `nibble_formatter`

## Requirements
- R1: After reset, and until the first captured word has passed through the latency delay, the data output is 4'b0000 (test mode off).
- R2: When a word launches, the bus shows bits [11:8], then [7:4], then [3:0] of the (possibly inverted) sample on three consecutive master-clock cycles, with the higher bit of each group on pin 3.
- R3: The fourth nibble is {1'b0, colour[1], colour[0], overrange}, where the colour code is 00 red, 01 green, 10 blue. This status nibble is held on the bus until the next word launches.
- R4: With invertEn = 1 at the strobe, the sample sent is 4095 minus the input sample. With invertEn = 0 it is sent unchanged.
- R5: With modeSlow = 0 and latency field L, the first nibble appears L*2+1 master-clock edges after the edge that samples the strobe. Until then the bus keeps its previous value.
- R6: With modeSlow = 1 and latency field L, the first nibble appears L*3+1 master-clock edges after the strobe edge.
- R7: A new strobe restarts the sequencer at the first nibble of the new word, even if the previous word is only partly sent.
- R8: With testClkEn = 1, the pins carry, from pin 3 down: the strobe registered once, the strobe registered twice, a converter-clock pulse that is high when the phase counter is 0, and a reset-sample pulse that is high when the phase counter is at its last count (1, or 2 in slow mode). The phase counter goes to 0 on the strobe edge. Data capture continues during test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample-valid strobe, one master clock wide |
| sampleIn | input | 12 | Conversion result |
| overRange | input | 1 | 1 = input exceeded range |
| colourCode | input | 2 | 00 red, 01 green, 10 blue |
| invertEn | input | 1 | Send 4095 minus the sample |
| latencySel | input | 2 | Extra delay in converter-clock periods (0 to 3) |
| testClkEn | input | 1 | Drive internal timing signals onto the bus |
| modeSlow | input | 1 | Converter clock is three master clocks instead of two |
| outNibble | output | 4 | Multiplexed output bus |

## Verification
Edge e0 is the clock edge that samples the strobe. The first nibble is due after edge e0 + L*D + 1, where D is 2 or 3 depending on modeSlow. The next three nibbles follow one per edge, and the status nibble must still be there one edge later. The bench counts falling edges from e0 and samples at exactly those points. When the delay is nonzero, it also samples one edge early to confirm the bus still shows the previous value. In test mode, the four pins are checked on the four edges after the strobe. Each value is worked out from the two register stages of the strobe and from the phase counter, which restarts at e0.

// File: rtl/nibfmt_pkg.sv
package nibfmt_pkg;
  localparam int SAMPLE_W = 12;
  localparam int NIB_W    = 4;
  localparam int MAX_LAT  = 3;
  localparam int DIV_FAST = 2;
  localparam int DIV_SLOW = 3;

  localparam int DATA_NIBS = SAMPLE_W / NIB_W;
  localparam int NIB_CNT   = DATA_NIBS + 1;
  localparam int WORD_W    = NIB_CNT * NIB_W;
  localparam int DLY_DEPTH = MAX_LAT * DIV_SLOW + 1;
  localparam int TAP_W     = $clog2(DLY_DEPTH);
  localparam int SEL_W     = $clog2(NIB_CNT);
  localparam int PHASE_W   = $clog2(DIV_SLOW);

  typedef struct packed {
    logic             capture;
    logic             load;
    logic             active;
    logic [SEL_W-1:0] nibSel;
    logic [TAP_W-1:0] tapIdx;
  } fmtCtl_t;
endpackage

// File: rtl/nibfmt_ctrl.sv
module nibfmt_ctrl
  import nibfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic [1:0] latencySel,
  input  logic       modeSlow,
  output fmtCtl_t    ctl,
  output logic [NIB_W-1:0] testPins
);
  logic [PHASE_W-1:0]   phaseCnt;
  logic [PHASE_W-1:0]   phaseLast;
  logic [DLY_DEPTH-1:0] stbLine;
  logic                 stbLate;
  logic [TAP_W-1:0]     tapIdx;
  logic                 launch;
  logic [SEL_W-1:0]     nibSel;
  logic                 active;

  always_comb begin
    phaseLast = modeSlow ? PHASE_W'(DIV_SLOW - 1) : PHASE_W'(DIV_FAST - 1);
    tapIdx    = TAP_W'(int'(latencySel) * (modeSlow ? DIV_SLOW : DIV_FAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phaseCnt <= '0;
    else if (sampleValid)        phaseCnt <= '0;
    else if (phaseCnt == phaseLast) phaseCnt <= '0;
    else                         phaseCnt <= phaseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbLine[0] <= 1'b0;
    else       stbLine[0] <= sampleValid;
  end

  for (genvar g = 1; g < DLY_DEPTH; g++) begin : gStb
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stbLine[g] <= 1'b0;
      else       stbLine[g] <= stbLine[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbLate <= 1'b0;
    else       stbLate <= stbLine[0];
  end

  assign launch = stbLine[tapIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibSel <= '0;
      active <= 1'b0;
    end else if (launch) begin
      nibSel <= '0;
      active <= 1'b1;
    end else if (active && nibSel != SEL_W'(NIB_CNT - 1)) begin
      nibSel <= nibSel + 1'b1;
    end
  end

  assign testPins = {stbLine[0], stbLate, phaseCnt == '0, phaseCnt == phaseLast};

  always_comb begin
    ctl.capture = sampleValid;
    ctl.load    = launch;
    ctl.active  = active;
    ctl.nibSel  = nibSel;
    ctl.tapIdx  = tapIdx;
  end
endmodule

// File: rtl/nibfmt_datapath.sv
module nibfmt_datapath
  import nibfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fmtCtl_t             ctl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                overRange,
  input  logic [1:0]          colourCode,
  input  logic                invertEn,
  input  logic                testClkEn,
  input  logic [NIB_W-1:0]    testPins,
  output logic [NIB_W-1:0]    outNibble
);
  localparam logic [SAMPLE_W-1:0] FULL_SCALE = '1;

  logic [SAMPLE_W-1:0] sampleAdj;
  logic [NIB_W-1:0]    statusNib;
  logic [WORD_W-1:0]   newWord;
  logic [WORD_W-1:0]   wordLine [DLY_DEPTH];
  logic [WORD_W-1:0]   curWord;
  logic [NIB_W-1:0]    nibArr [NIB_CNT];
  logic [NIB_W-1:0]    dataNib;

  always_comb begin
    sampleAdj = invertEn ? (FULL_SCALE - sampleIn) : sampleIn;
    statusNib = {{(NIB_W-3){1'b0}}, colourCode, overRange};
    newWord   = {sampleAdj, statusNib};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordLine[0] <= '0;
    else if (ctl.capture) wordLine[0] <= newWord;
    else                  wordLine[0] <= '0;
  end

  for (genvar g = 1; g < DLY_DEPTH; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordLine[g] <= '0;
      else       wordLine[g] <= wordLine[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         curWord <= '0;
    else if (ctl.load) curWord <= wordLine[ctl.tapIdx];
  end

  for (genvar n = 0; n < NIB_CNT; n++) begin : gNib
    assign nibArr[n] = curWord[WORD_W-1-n*NIB_W -: NIB_W];
  end

  always_comb begin
    dataNib   = ctl.active ? nibArr[ctl.nibSel] : '0;
    outNibble = testClkEn ? testPins : dataNib;
  end
endmodule

// File: rtl/nibble_formatter.sv
module nibble_formatter
  import nibfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                overRange,
  input  logic [1:0]          colourCode,
  input  logic                invertEn,
  input  logic [1:0]          latencySel,
  input  logic                testClkEn,
  input  logic                modeSlow,
  output logic [NIB_W-1:0]    outNibble
);
  fmtCtl_t          ctl;
  logic [NIB_W-1:0] testPins;

  nibfmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .latencySel(latencySel), .modeSlow(modeSlow),
    .ctl(ctl), .testPins(testPins)
  );

  nibfmt_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .overRange(overRange), .colourCode(colourCode), .invertEn(invertEn),
    .testClkEn(testClkEn), .testPins(testPins), .outNibble(outNibble)
  );
endmodule

// File: rtl/nibble_formatter_checker.sv
module nibble_formatter_checker (
  input logic        clk,
  input logic        rstN,
  input logic        sampleValid,
  input logic [11:0] sampleIn,
  input logic        invertEn,
  input logic [1:0]  latencySel,
  input logic        testClkEn,
  input logic [3:0]  outNibble
);
  logic       seenStrobe;
  logic [1:0] upTime;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenStrobe <= 1'b0;
      upTime     <= '0;
    end else begin
      if (sampleValid) seenStrobe <= 1'b1;
      if (upTime != 2'd3) upTime <= upTime + 1'b1;
    end
  end

  assert_quiet_before_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!seenStrobe && !testClkEn) |-> outNibble == 4'h0);

  assert_first_nibble_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && latencySel == 2'd0 && !invertEn) ##1 (latencySel == 2'd0) ##1 !testClkEn
    |-> outNibble == $past(sampleIn[11:8], 2));

  assert_first_nibble_inverted_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && latencySel == 2'd0 && invertEn) ##1 (latencySel == 2'd0) ##1 !testClkEn
    |-> outNibble == 4'hF - $past(sampleIn[11:8], 2));

  assert_test_pulse_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testClkEn && upTime != 2'd0) |-> outNibble[3] == $past(sampleValid));

  assert_test_video_pin_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testClkEn && upTime >= 2'd2) |-> outNibble[2] == $past(sampleValid, 2));
endmodule

bind nibble_formatter nibble_formatter_checker u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
  .invertEn(invertEn), .latencySel(latencySel), .testClkEn(testClkEn),
  .outNibble(outNibble)
);

// File: tb/tb_nibble_formatter.sv
module tb_nibble_formatter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        overRange = 1'b0;
  logic [1:0]  colourCode = '0;
  logic        invertEn = 1'b0;
  logic [1:0]  latencySel = '0;
  logic        testClkEn = 1'b0;
  logic        modeSlow = 1'b0;
  logic [3:0]  outNibble;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [3:0] lastD = 4'h0;

  always #4 clk = ~clk;

  nibble_formatter dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .overRange(overRange), .colourCode(colourCode), .invertEn(invertEn),
    .latencySel(latencySel), .testClkEn(testClkEn), .modeSlow(modeSlow),
    .outNibble(outNibble)
  );

  // vector: [18:7] sample, [6] overrange, [5:4] colour, [3] invert, [2:1] latency, [0] slow
  localparam logic [18:0] VECS [8] = '{
    {12'hABC, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0},
    {12'h123, 1'b1, 2'b01, 1'b0, 2'd1, 1'b0},
    {12'hFFF, 1'b0, 2'b10, 1'b1, 2'd0, 1'b0},
    {12'h000, 1'b1, 2'b10, 1'b0, 2'd2, 1'b0},
    {12'h5A3, 1'b0, 2'b01, 1'b1, 2'd3, 1'b0},
    {12'h800, 1'b0, 2'b00, 1'b0, 2'd1, 1'b1},
    {12'h7FE, 1'b1, 2'b00, 1'b1, 2'd3, 1'b1},
    {12'h9D2, 1'b0, 2'b01, 1'b0, 2'd2, 1'b1}
  };

  function automatic logic [15:0] expWord(input logic [11:0] s, input logic ovr,
                                          input logic [1:0] cc, input logic inv);
    logic [11:0] v;
    v = inv ? 12'(4095 - int'(s)) : s;
    return {v, 1'b0, cc, ovr};
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    nChecks++;
    if (outNibble !== exp) begin
      nFails++;
      $display("FAIL %s: outNibble=%h expected %h", tag, outNibble, exp);
    end
  endtask

  task automatic strobe(input logic [11:0] s, input logic ovr, input logic [1:0] cc,
                        input logic inv, input logic [1:0] lat, input logic slow);
    @(negedge clk);
    sampleIn = s; overRange = ovr; colourCode = cc; invertEn = inv;
    latencySel = lat; modeSlow = slow; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic runWord(input logic [11:0] s, input logic ovr, input logic [1:0] cc,
                         input logic inv, input logic [1:0] lat, input logic slow,
                         input string preTag);
    logic [15:0] w;
    int t;
    string latTag;
    string datTag;
    w = expWord(s, ovr, cc, inv);
    t = int'(lat) * (slow ? 3 : 2);
    latTag = slow ? "R6" : "R5";
    datTag = inv ? "R4" : "R2";
    strobe(s, ovr, cc, inv, lat, slow);
    if (t > 0) begin
      repeat (t) @(negedge clk);
      check(lastD, {preTag, " before launch"});
    end
    @(negedge clk); check(w[15:12], {latTag, "/", datTag, " nibble A"});
    @(negedge clk); check(w[11:8],  {datTag, " nibble B"});
    @(negedge clk); check(w[7:4],   {datTag, " nibble C"});
    @(negedge clk); check(w[3:0],   "R3 status nibble");
    @(negedge clk); check(w[3:0],   "R3 status nibble held");
    lastD = w[3:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, outNibble=%h expected completion", outNibble);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(4'h0, "R1 in reset");
    rstN = 1'b1;
    latencySel = 2'd3;
    repeat (4) @(negedge clk);
    check(4'h0, "R1 idle after reset");
    // R1: still zero while first word is in the delay line (6 cycles)
    runWord(12'h3C6, 1'b1, 2'b01, 1'b0, 2'd3, 1'b0, "R1");

    // table of vectors
    for (int i = 0; i < 8; i++) begin
      runWord(VECS[i][18:7], VECS[i][6], VECS[i][5:4], VECS[i][3],
              VECS[i][2:1], VECS[i][0], VECS[i][0] ? "R6" : "R5");
    end

    // R7: restart mid-sequence, latency 0
    strobe(12'h4E7, 1'b0, 2'b10, 1'b0, 2'd0, 1'b0);  // edge e0
    @(negedge clk); check(4'h4, "R7 first word A");   // after e1
    sampleIn = 12'hB19; colourCode = 2'b01; overRange = 1'b1; sampleValid = 1'b1;
    @(negedge clk); sampleValid = 1'b0;
    check(4'hE, "R7 first word B");                   // after e2
    @(negedge clk); check(4'hB, "R7 restart at A");   // after e3
    @(negedge clk); check(4'h1, "R7 new word B");
    @(negedge clk); check(4'h9, "R7 new word C");
    @(negedge clk); check(4'h3, "R7 new word status");

    // R8: test mode, normal divide
    testClkEn = 1'b1;
    strobe(12'h6D1, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0);
    check(4'b1010, "R8 fast edge0");
    @(negedge clk); check(4'b0101, "R8 fast edge1");
    @(negedge clk); check(4'b0010, "R8 fast edge2");
    @(negedge clk); check(4'b0001, "R8 fast edge3");
    // R8: test mode, slow divide
    strobe(12'h2F0, 1'b1, 2'b10, 1'b1, 2'd0, 1'b1);
    check(4'b1010, "R8 slow edge0");
    @(negedge clk); check(4'b0100, "R8 slow edge1");
    @(negedge clk); check(4'b0001, "R8 slow edge2");
    @(negedge clk); check(4'b0010, "R8 slow edge3");
    // R8: data kept flowing underneath test mode
    repeat (3) @(negedge clk);
    testClkEn = 1'b0;
    w = expWord(12'h2F0, 1'b1, 2'b10, 1'b1);
    #1 check(w[3:0], "R8 data after test mode");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule